// File: doc/BRIEF.md
# I/O Space Route Decoder

This block steers I/O-space requests across a multi-node fabric. It holds a small set of programmable window pairs. Each pair has a base word and a limit word. A 25-bit I/O address is compared against every window in parallel, and the decoder reports whether the address is claimed and which node and link should carry the request. Each window is granted separately for reads and for writes.

Each window can also apply two legacy behaviours. The display-adapter mode claims the classic display port ranges anywhere in the first 64K, whatever the window bounds are. The ISA-alias mode stops the window's range compare from claiming the upper three quarters of every 1K block in the first 64K. Software programs the windows through a simple word-addressed register port. The lookup path returns its answer one clock after the request.

Top module: `pio_route_decoder`

## Requirements
- R1: A synchronous active-high reset clears every register word to zero. In the cycle after reset, `dec_hit`, `dec_node` and `dec_link` are zero.
- R2: `cfg_addr[0]` selects the limit word (1) or the base word (0), and `cfg_addr[2:1]` selects the pair. `cfg_rdata` returns the addressed word combinationally. Base words keep only bits 0, 1, 4, 5 and 24:12, limit words keep only bits 2:0, 5:4 and 24:12, and every other bit reads as zero.
- R3: A pair's range holds an address when A[24:12] lies between base[24:12] and limit[24:12], both bounds included. A request sampled on one rising edge shows its result on the outputs after that edge.
- R4: A read request (`io_write`=0) can only be claimed by a pair whose base bit 0 is set. A write request (`io_write`=1) can only be claimed by a pair whose base bit 1 is set.
- R5: When base bit 4 is set, any address below 0x10000 whose A[9:0] lies in 0x3B0..0x3BB or 0x3C0..0x3DF is claimed by the pair, whatever its bounds are.
- R6: When base bit 5 is set, an address below 0x10000 with A[9:8] not equal to 00 cannot be claimed through the range compare. The bit-4 match of R5 is not affected.
- R7: When several pairs claim an address, the lowest-numbered pair wins. `dec_node` is then that pair's limit[2:0] and `dec_link` is its limit[5:4].
- R8: A pair whose limit[5:4] holds the reserved value 3 claims nothing.
- R9: When `req_valid` is low or no pair claims the address, `dec_hit`, `dec_node` and `dec_link` are zero in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word select: pair in [2:1], limit in [0] |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read-back of the selected word |
| req_valid | input | 1 | A lookup request is present |
| io_write | input | 1 | 1 = write request, 0 = read request |
| io_addr | input | 25 | I/O address to decode |
| dec_hit | output | 1 | Registered: the address was claimed |
| dec_node | output | 3 | Registered destination node |
| dec_link | output | 2 | Registered destination link |

## Verification
The assertions assume that `rst` is held for at least one clock before any request is judged. They also assume that `cfg_addr` only ever selects an existing pair word, which is always true at the default of four pairs because every 3-bit value is legal. Register writes may share a cycle with a lookup, and that lookup must see the old window contents. The stimulus drives every input at the falling edge, exercises writes during lookups, and leans toward addresses below 64K so that the legacy modes and windows overlap often.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int ADDR_W    = 25;
    localparam int PAGE_LSB  = 12;
    localparam int PAGE_W    = ADDR_W - PAGE_LSB;
    localparam int NODE_W    = 3;
    localparam int LINK_W    = 2;
    localparam int LEGACY_W  = 16;
    localparam int DATA_W    = 32;

    localparam logic [LINK_W-1:0] LINK_RSVD = '1;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              isa_en;
        logic              vga_en;
        logic              wr_en;
        logic              rd_en;
    } pio_base_t;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [LINK_W-1:0] link;
        logic [NODE_W-1:0] node;
    } pio_limit_t;

    typedef struct packed {
        logic              hit;
        logic [NODE_W-1:0] node;
        logic [LINK_W-1:0] link;
    } pio_route_t;

    function automatic pio_base_t unpack_base(input logic [DATA_W-1:0] w);
        pio_base_t b;
        b.page   = w[PAGE_LSB +: PAGE_W];
        b.isa_en = w[5];
        b.vga_en = w[4];
        b.wr_en  = w[1];
        b.rd_en  = w[0];
        return b;
    endfunction

    function automatic pio_limit_t unpack_limit(input logic [DATA_W-1:0] w);
        pio_limit_t l;
        l.page = w[PAGE_LSB +: PAGE_W];
        l.link = w[5:4];
        l.node = w[2:0];
        return l;
    endfunction

    function automatic logic [DATA_W-1:0] pack_base(input pio_base_t b);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PAGE_LSB +: PAGE_W] = b.page;
        w[5] = b.isa_en;
        w[4] = b.vga_en;
        w[1] = b.wr_en;
        w[0] = b.rd_en;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_limit(input pio_limit_t l);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PAGE_LSB +: PAGE_W] = l.page;
        w[5:4] = l.link;
        w[2:0] = l.node;
        return w;
    endfunction

    // Address lies in the legacy first-64K region
    function automatic logic in_legacy(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:LEGACY_W] == '0;
    endfunction

    // Classic display adapter port windows within each 1K block
    function automatic logic display_port(input logic [9:0] lo);
        return ((lo >= 10'h3B0) && (lo <= 10'h3BB)) ||
               ((lo >= 10'h3C0) && (lo <= 10'h3DF));
    endfunction

    // Upper 768 bytes of a 1K block are ISA aliases
    function automatic logic isa_alias(input logic [ADDR_W-1:0] a);
        return in_legacy(a) && (a[9:8] != 2'b00);
    endfunction

endpackage

// File: rtl/pio_regfile.sv
module pio_regfile
    import pio_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    localparam int SEL_W    = $clog2(NUM_PAIRS) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output pio_base_t         base_q  [NUM_PAIRS],
    output pio_limit_t        limit_q [NUM_PAIRS]
);

    localparam int PAIR_W = SEL_W - 1;

    logic [PAIR_W-1:0] sel_pair;
    logic              sel_limit;

    assign sel_pair  = cfg_addr[SEL_W-1:1];
    assign sel_limit = cfg_addr[0];

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[p]  <= '0;
                limit_q[p] <= '0;
            end else if (cfg_we && (sel_pair == PAIR_W'(p))) begin
                if (sel_limit) limit_q[p] <= unpack_limit(cfg_wdata);
                else           base_q[p]  <= unpack_base(cfg_wdata);
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (sel_pair == PAIR_W'(p)) begin
                cfg_rdata = sel_limit ? pack_limit(limit_q[p]) : pack_base(base_q[p]);
            end
        end
    end

endmodule

// File: rtl/pio_pair_match.sv
module pio_pair_match
    import pio_pkg::*;
(
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_write,
    input  pio_base_t         base,
    input  pio_limit_t        limit,
    output logic              match
);

    logic [PAGE_W-1:0] page;
    logic              allowed;
    logic              in_range;
    logic              legacy_disp;
    logic              alias_block;

    assign page        = io_addr[ADDR_W-1:PAGE_LSB];
    assign allowed     = (io_write ? base.wr_en : base.rd_en) && (limit.link != LINK_RSVD);
    assign in_range    = (page >= base.page) && (page <= limit.page);
    assign legacy_disp = base.vga_en && in_legacy(io_addr) && display_port(io_addr[9:0]);
    assign alias_block = base.isa_en && isa_alias(io_addr);

    assign match = allowed && (legacy_disp || (in_range && !alias_block));

endmodule

// File: rtl/pio_pick.sv
module pio_pick
    import pio_pkg::*;
#(
    parameter int NUM_PAIRS = 4
) (
    input  logic [NUM_PAIRS-1:0] pair_hit,
    input  pio_limit_t           limit_q [NUM_PAIRS],
    output pio_route_t           route
);

    always_comb begin
        route = '0;
        for (int p = NUM_PAIRS - 1; p >= 0; p--) begin
            if (pair_hit[p]) begin
                route.hit  = 1'b1;
                route.node = limit_q[p].node;
                route.link = limit_q[p].link;
            end
        end
    end

endmodule

// File: rtl/pio_route_decoder.sv
module pio_route_decoder
    import pio_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    localparam int SEL_W    = $clog2(NUM_PAIRS) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic              io_write,
    input  logic [24:0]       io_addr,
    output logic              dec_hit,
    output logic [2:0]        dec_node,
    output logic [1:0]        dec_link
);

    pio_base_t            base_q  [NUM_PAIRS];
    pio_limit_t           limit_q [NUM_PAIRS];
    logic [NUM_PAIRS-1:0] pair_hit;
    pio_route_t           route_d;
    pio_route_t           route_q;

    pio_regfile #(.NUM_PAIRS(NUM_PAIRS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .base_q    (base_q),
        .limit_q   (limit_q)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_match
        pio_pair_match u_match (
            .io_addr  (io_addr),
            .io_write (io_write),
            .base     (base_q[p]),
            .limit    (limit_q[p]),
            .match    (pair_hit[p])
        );
    end

    pio_pick #(.NUM_PAIRS(NUM_PAIRS)) u_pick (
        .pair_hit (pair_hit),
        .limit_q  (limit_q),
        .route    (route_d)
    );

    always_ff @(posedge clk) begin
        if (rst || !req_valid) route_q <= '0;
        else                   route_q <= route_d;
    end

    assign dec_hit  = route_q.hit;
    assign dec_node = route_q.node;
    assign dec_link = route_q.link;

endmodule

// File: rtl/pio_route_decoder_chk.sv
module pio_route_decoder_chk #(
    parameter int NUM_PAIRS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic [NUM_PAIRS-1:0] pair_hit,
    input logic                 dec_hit,
    input logic [2:0]           dec_node,
    input logic [1:0]           dec_link
);

    AST_RST_QUIET: assert property (@(posedge clk) rst |=> !dec_hit); // R1

    AST_IDLE_MISS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !dec_hit); // R9

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !dec_hit |-> (dec_node == 3'd0 && dec_link == 2'd0)); // R9

    AST_NO_CLAIM_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && pair_hit == '0) |=> !dec_hit); // R3

    AST_CLAIM_GIVES_HIT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && pair_hit != '0) |=> dec_hit); // R7

    AST_LINK_LEGAL: assert property (@(posedge clk) disable iff (rst)
        dec_hit |-> dec_link != 2'd3); // R8

endmodule

bind pio_route_decoder pio_route_decoder_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .pair_hit  (pair_hit),
    .dec_hit   (dec_hit),
    .dec_node  (dec_node),
    .dec_link  (dec_link)
);

// File: tb/test_pio_route_decoder.sv
module test_pio_route_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        io_write = 1'b0;
    logic [24:0] io_addr = '0;
    logic        dec_hit;
    logic [2:0]  dec_node;
    logic [1:0]  dec_link;

    always #2.5 clk = ~clk;

    pio_route_decoder i_pio_route_decoder (
        .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
        .req_valid, .io_write, .io_addr, .dec_hit, .dec_node, .dec_link
    );

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    logic [31:0] mb [4];
    logic [31:0] ml [4];
    bit          have_exp = 0;
    logic [5:0]  exp_route;
    logic [31:0] exp_rdata;

    function automatic logic [5:0] model_decode(input bit v, input bit w, input logic [24:0] a);
        int lo;
        int pg;
        bit low;
        if (!v) return 6'd0;
        lo  = int'(a) % 1024;
        pg  = int'(a) >> 12;
        low = int'(a) < 'h10000;
        for (int i = 0; i < 4; i++) begin
            bit perm, vga, isa, inr;
            perm = w ? mb[i][1] : mb[i][0];
            if (!perm || ml[i][5:4] == 2'd3) continue;
            vga = mb[i][4] && low && ((lo >= 'h3B0 && lo <= 'h3BB) || (lo >= 'h3C0 && lo <= 'h3DF));
            inr = pg >= int'(mb[i][24:12]) && pg <= int'(ml[i][24:12]);
            isa = mb[i][5] && low && (lo >= 256);
            if (vga || (inr && !isa)) return {1'b1, ml[i][2:0], ml[i][5:4]};
        end
        return 6'd0;
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit r, input bit we, input int ra, input logic [31:0] wd,
                        input bit v, input bit w, input logic [24:0] a);
        @(negedge clk);
        if (have_exp) begin
            check("route{hit,node,link}", {26'd0, dec_hit, dec_node, dec_link}, {26'd0, exp_route});
            check("cfg_rdata", cfg_rdata, exp_rdata);
        end
        rst = r; cfg_we = we; cfg_addr = ra[2:0]; cfg_wdata = wd;
        req_valid = v; io_write = w; io_addr = a;
        if (r) begin
            for (int i = 0; i < 4; i++) begin mb[i] = 0; ml[i] = 0; end
            exp_route = 0;
        end else begin
            exp_route = model_decode(v, w, a);
            if (we) begin
                if (ra % 2 == 1) ml[ra / 2] = wd & 32'h01FFF037;
                else             mb[ra / 2] = wd & 32'h01FFF033;
            end
        end
        exp_rdata = (ra % 2 == 1) ? ml[ra / 2] : mb[ra / 2];
        have_exp = 1;
    endtask

    task automatic wr(input int ra, input logic [31:0] wd);
        step(0, 1, ra, wd, 0, 0, '0);
    endtask

    task automatic look(input bit w, input logic [24:0] a);
        step(0, 0, 0, '0, 1, w, a);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state, every word reads zero
        tag = "R1";
        step(1, 0, 0, '0, 1, 0, 25'h3000);
        step(1, 0, 0, '0, 0, 0, '0);
        for (int i = 0; i < 8; i++) step(0, 0, i, '0, 1, 0, 25'h0);

        // R2: reserved bits read zero, layout kept
        tag = "R2";
        wr(0, 32'hFFFF_FFFF);
        wr(1, 32'hFFFF_FFFF);
        step(0, 0, 0, '0, 0, 0, '0);
        step(0, 0, 1, '0, 0, 0, '0);
        wr(6, 32'hA5A5_A5A5);
        wr(7, 32'h5A5A_5A5A);
        step(0, 0, 6, '0, 0, 0, '0);
        wr(0, 0); wr(1, 0); wr(6, 0); wr(7, 0);

        // R3: inclusive 4K range compare, node 5 link 1
        tag = "R3";
        wr(1, 32'h0000_5015);
        wr(0, 32'h0000_3003);
        look(0, 25'h2FFF); look(0, 25'h3000); look(1, 25'h5FFF); look(0, 25'h6000);

        // R4: read/write permissions
        tag = "R4";
        wr(0, 32'h0000_3001);
        look(0, 25'h4000); look(1, 25'h4000);
        wr(0, 32'h0000_3002);
        look(0, 25'h4000); look(1, 25'h4000);
        wr(0, 0);

        // R5: display ports claimed regardless of bounds
        tag = "R5";
        wr(3, 32'h00F0_0022);
        wr(2, 32'h00F0_0013);
        look(0, 25'h03B5); look(1, 25'h13C0); look(0, 25'h03BC); look(0, 25'h03AF);
        look(0, 25'h03DF); look(0, 25'h03E0); look(0, 25'h103B0); look(0, 25'hF00123);
        wr(2, 0);

        // R6: ISA alias suppression of the range compare only
        tag = "R6";
        wr(5, 32'h0000_F006);
        wr(4, 32'h0000_0023);
        look(0, 25'h0050); look(0, 25'h0100); look(0, 25'h0400); look(0, 25'h07FF);
        wr(4, 32'h0000_0033);
        look(0, 25'h03C0); look(0, 25'h02F0);
        wr(4, 0);

        // R7: lowest pair wins
        tag = "R7";
        wr(1, 32'h0000_2004); wr(0, 32'h0000_1003);
        wr(7, 32'h0000_3017); wr(6, 32'h0000_1003);
        look(0, 25'h1800); look(1, 25'h2800); look(0, 25'h3FFF);

        // R8: reserved link value disables the pair
        tag = "R8";
        wr(1, 32'h0000_2034);
        look(0, 25'h1800); look(0, 25'h1000);

        // R9: no request, no hit
        tag = "R9";
        step(0, 0, 0, '0, 0, 0, 25'h1800);
        look(0, 25'h00FF_FFFF);

        // Mixed traffic, writes during lookups
        tag = "R7";
        for (int n = 0; n < 3000; n++) begin
            bit we_r;
            logic [24:0] a;
            logic [31:0] d;
            we_r = ($urandom % 8) == 0;
            d = $urandom;
            if (($urandom % 2) == 0) d[24:16] = '0;
            a = $urandom;
            if (($urandom % 4) != 0) a[24:16] = '0;
            if (($urandom % 4) == 0) a[9:0] = 10'h3A8 + 10'($urandom % 64);
            step(0, we_r, int'($urandom % 8), d, ($urandom % 8) != 0, $urandom % 2, a);
        end

        step(0, 0, 0, '0, 0, 0, '0);
        step(0, 0, 0, '0, 0, 0, '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule